// File: doc/BRIEF.md
# Pause-Width Reader Bit Encoder

This block sends a short reader-to-tag frame of up to sixteen bits by switching a carrier-enable line. Each bit opens with a carrier-off gap of fixed length. The carrier then comes back on for the rest of the bit. The value of a bit is carried only by how long the whole bit lasts: a one is long and a zero is short. After the last data bit, one more carrier-off gap closes the frame. The carrier then stays on until the next frame.

All durations are counted in ticks, and a built-in prescaler makes one tick from every `TICK_DIV` system clocks. A frame starts with a one-cycle start strobe, which also captures the data word and the bit count. The prescaler is restarted at that moment, so the frame timing is fixed relative to the strobe. The prescaler tick is driven out for a shared response timer. At frame end the block pulses a timer-clear output together with its done pulse, so later waits can be measured from the end of the frame.

Top module: `pause_frame_tx`

## Requirements
- R1: Right after reset, `carrier_o` is 1, `busy_o` is 0, `done_o` is 0 and `timer_clr_o` is 0.
- R2: `tick_o` is high for one clock in every `TICK_DIV` clocks. An accepted start restarts the prescaler, so `tick_o` is high in cycles m where m mod `TICK_DIV` = `TICK_DIV`-1. Here m = 0 is the cycle right after the clock edge that accepted the start.
- R3: Every data bit begins with `carrier_o` at 0 for `PAUSE_TICKS` ticks, which is `PAUSE_TICKS*TICK_DIV` clocks. `carrier_o` is 1 for the rest of the bit.
- R4: A bit whose value is 1 lasts `ONE_TICKS` ticks in total. A bit whose value is 0 lasts `ZERO_TICKS` ticks. The next bit starts directly after it.
- R5: Bits are sent from `data_i[0]` upward, using the word captured at the accepted start.
- R6: After the last data bit, `carrier_o` is 0 for a closing `PAUSE_TICKS` ticks and then returns to 1.
- R7: A bit count above `MAX_BITS` is treated as `MAX_BITS`. A count of 0 sends only the closing gap.
- R8: A start request made while `busy_o` is 1 is ignored. The frame in progress goes on with its waveform unchanged.
- R9: `busy_o` is 1 from cycle m = 0 until the frame ends. At the frame end `done_o` is 1 for exactly one cycle, and `busy_o` falls in that same cycle.
- R10: `timer_clr_o` pulses in the same cycle as `done_o` and at no other time.
- R11: `carrier_o` is 1 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| data_i | input | MAX_BITS | Frame bits, bit 0 sent first |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of bits to send |
| carrier_o | output | 1 | Carrier enable, 0 means carrier off |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| timer_clr_o | output | 1 | One-cycle restart for the shared response timer |
| tick_o | output | 1 | Prescaled tick enable |

## Verification
Every output is a register, or is decoded from a register, that changes on the clock edge that accepts the start or on a tick edge. With the start-accepting edge numbered as cycle 0, the bench computes the expected value of each output at every cycle. The carrier edges fall at multiples of `TICK_DIV` set by the running sum of the bit lengths. The done and timer-clear pulses are due at exactly `(sum of bit lengths + PAUSE_TICKS)*TICK_DIV` clocks. Every output is sampled at the falling edge of every cycle, from cycle 0 up to one cycle past the frame end. This checks the idle level after the frame as well as each in-frame transition at the exact cycle it is due.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BIT   = 2'd1,
    ST_CLOSE = 2'd2
  } pft_state_e;

  // Length in ticks of one bit, chosen by its value
  function automatic int unsigned bit_ticks(input logic b,
                                            input int unsigned one_t,
                                            input int unsigned zero_t);
    return b ? one_t : zero_t;
  endfunction

  // Requested bit count limited to the frame capacity
  function automatic int unsigned clamp_bits(input int unsigned req,
                                             input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction
endpackage

// File: rtl/pft_tick_div.sv
module pft_tick_div #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pft_shift.sv
module pft_shift #(
  parameter int unsigned MAXB = 16,
  parameter int unsigned CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [MAXB-1:0] data_i,
  input  logic [CNTW-1:0] nbits_i,
  output logic            cur_bit,
  output logic            last_bit
);
  logic [MAXB-1:0] sreg;
  logic [CNTW-1:0] remaining;

  assign cur_bit  = sreg[0];
  assign last_bit = (remaining == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      remaining <= '0;
    end else if (load) begin
      sreg      <= data_i;
      remaining <= CNTW'(pft_pkg::clamp_bits(int'(nbits_i), MAXB));
    end else if (adv) begin
      sreg      <= sreg >> 1;
      remaining <= remaining - 1'b1;
    end
  end

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(sreg));

  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remaining <= CNTW'(MAXB));
endmodule

// File: rtl/pft_seq.sv
module pft_seq #(
  parameter int unsigned PAUSE = 30,
  parameter int unsigned ONE   = 150,
  parameter int unsigned ZERO  = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic zero_len,
  input  logic cur_bit,
  input  logic last_bit,
  output logic load,
  output logic adv,
  output logic carrier,
  output logic busy,
  output logic done,
  output logic tclr
);
  import pft_pkg::*;

  localparam int unsigned MAXT = (ONE > ZERO) ? ONE : ZERO;
  localparam int unsigned TW   = $clog2(MAXT + 1);

  pft_state_e    state;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] tnext;
  logic [TW-1:0] period;
  logic          bit_end;
  logic          close_end;

  assign tnext     = tcnt + 1'b1;
  assign period    = TW'(bit_ticks(cur_bit, ONE, ZERO));
  assign load      = start && (state == ST_IDLE);
  assign bit_end   = (state == ST_BIT) && tick && (tnext == period);
  assign close_end = (state == ST_CLOSE) && tick && (tnext == TW'(PAUSE));
  assign adv       = bit_end;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      carrier <= 1'b1;
      done    <= 1'b0;
      tclr    <= 1'b0;
    end else begin
      done <= 1'b0;
      tclr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            tcnt    <= '0;
            carrier <= 1'b0;
            state   <= zero_len ? ST_CLOSE : ST_BIT;
          end
        end
        ST_BIT: begin
          if (tick) begin
            tcnt <= tnext;
            if (tnext == TW'(PAUSE)) carrier <= 1'b1;
            if (bit_end) begin
              tcnt    <= '0;
              carrier <= 1'b0;
              state   <= last_bit ? ST_CLOSE : ST_BIT;
            end
          end
        end
        ST_CLOSE: begin
          if (tick) begin
            tcnt <= tnext;
            if (close_end) begin
              tcnt    <= '0;
              carrier <= 1'b1;
              done    <= 1'b1;
              tclr    <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  idle_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> carrier);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  bit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BIT) |-> (tcnt < period));

  // R3
  pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tcnt < TW'(PAUSE) && !(tick && tnext == TW'(PAUSE))) |=> !carrier);

  // R10
  tclr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tclr |-> done);
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int unsigned TICK_DIV    = 32,
  parameter int unsigned PAUSE_TICKS = 30,
  parameter int unsigned ONE_TICKS   = 150,
  parameter int unsigned ZERO_TICKS  = 90,
  parameter int unsigned MAX_BITS    = 16,
  localparam int unsigned CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [CNT_W-1:0]    nbits_i,
  output logic                carrier_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                timer_clr_o,
  output logic                tick_o
);
  logic frame_load;
  logic bit_adv;
  logic cur_bit;
  logic last_bit;
  logic zero_len;

  assign zero_len = (nbits_i == '0);

  pft_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (frame_load),
    .tick    (tick_o)
  );

  pft_shift #(.MAXB(MAX_BITS), .CNTW(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_load),
    .adv      (bit_adv),
    .data_i   (data_i),
    .nbits_i  (nbits_i),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  pft_seq #(.PAUSE(PAUSE_TICKS), .ONE(ONE_TICKS), .ZERO(ZERO_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .tick     (tick_o),
    .zero_len (zero_len),
    .cur_bit  (cur_bit),
    .last_bit (last_bit),
    .load     (frame_load),
    .adv      (bit_adv),
    .carrier  (carrier_o),
    .busy     (busy_o),
    .done     (done_o),
    .tclr     (timer_clr_o)
  );

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  // R6
  done_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> carrier_o);
endmodule

// File: tb/test_pause_frame_tx.sv
module test_pause_frame_tx;
  localparam int DIV = 2;
  localparam int PZ  = 3;
  localparam int ONE = 7;
  localparam int ZER = 5;
  localparam int MB  = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_i = 0;
  logic [15:0] data_i = '0;
  logic [4:0]  nbits_i = '0;
  logic        carrier_o, busy_o, done_o, timer_clr_o, tick_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_frame_tx #(.TICK_DIV(DIV), .PAUSE_TICKS(PZ), .ONE_TICKS(ONE),
                   .ZERO_TICKS(ZER), .MAX_BITS(MB)) i_pause_frame_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .nbits_i(nbits_i), .carrier_o(carrier_o), .busy_o(busy_o),
    .done_o(done_o), .timer_clr_o(timer_clr_o), .tick_o(tick_o));

  function automatic int eff_bits(int n);
    return (n > MB) ? MB : n;
  endfunction

  function automatic int frame_end(logic [15:0] d, int n);
    int pos = 0;
    for (int i = 0; i < eff_bits(n); i++) pos += (d[i] ? ONE : ZER) * DIV;
    return pos + PZ * DIV;
  endfunction

  function automatic logic exp_carrier(logic [15:0] d, int n, int m);
    int pos = 0;
    for (int i = 0; i < eff_bits(n); i++) begin
      int len = (d[i] ? ONE : ZER) * DIV;
      if (m < pos + len) return (m - pos) >= PZ * DIV;
      pos += len;
    end
    return m >= pos + PZ * DIV;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Sends one frame and checks all outputs at every cycle of it
  task automatic run_frame(logic [15:0] d, int n, bit inject, string tag);
    int fe = frame_end(d, n);
    int e_car = 0, e_busy = 0, e_done = 0, e_clr = 0, e_tick = 0;
    int a_car = -1, x_car = -1, a_busy = -1, x_busy = -1;
    int a_done = -1, x_done = -1, a_clr = -1, x_clr = -1, a_tick = -1, x_tick = -1;
    @(negedge clk);
    data_i = d; nbits_i = 5'(n); start_i = 1;
    @(posedge clk);
    for (int m = 0; m <= fe + 1; m++) begin
      @(negedge clk);
      start_i = 0;
      if (inject && (m == 4 || m == fe - 2)) begin
        start_i = 1; data_i = ~d; nbits_i = 5'd1;
      end
      if (carrier_o !== exp_carrier(d, n, m) && e_car == 0) begin
        e_car = 1; a_car = carrier_o; x_car = exp_carrier(d, n, m);
      end
      if (busy_o !== (m < fe) && e_busy == 0) begin
        e_busy = 1; a_busy = busy_o; x_busy = (m < fe);
      end
      if (done_o !== (m == fe) && e_done == 0) begin
        e_done = 1; a_done = done_o; x_done = (m == fe);
      end
      if (timer_clr_o !== (m == fe) && e_clr == 0) begin
        e_clr = 1; a_clr = timer_clr_o; x_clr = (m == fe);
      end
      if (tick_o !== ((m % DIV) == DIV - 1) && e_tick == 0) begin
        e_tick = 1; a_tick = tick_o; x_tick = ((m % DIV) == DIV - 1);
      end
    end
    start_i = 0;
    chk({tag, " R3 R4 R5 R6 R11"}, "carrier", a_car, x_car);
    chk({tag, " R9"}, "busy", a_busy, x_busy);
    chk({tag, " R9"}, "done", a_done, x_done);
    chk({tag, " R10"}, "timer_clr", a_clr, x_clr);
    chk({tag, " R2"}, "tick", a_tick, x_tick);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "carrier", carrier_o, 1);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "timer_clr", timer_clr_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R11: carrier on while idle after reset
    chk("R11", "idle carrier", carrier_o, 1);
    // R3 R4 R5 R6 sweep; R7 for count 0 and counts above 16
    for (int n = 0; n < 32; n++) begin
      run_frame(16'hFFFF, n, 0, (n == 0 || n > MB) ? "R7" : "R4");
      run_frame(16'h0000, n, 0, (n == 0 || n > MB) ? "R7" : "R4");
      run_frame(16'hA5C3, n, 0, (n == 0 || n > MB) ? "R7" : "R5");
    end
    for (int k = 0; k < 8; k++) run_frame(16'(k * 16'h2F1B + 16'h0137), 1 + k * 2, 0, "R5");
    // R8: start requests while busy are ignored
    run_frame(16'h0F31, 9, 1, "R8");
    run_frame(16'hC0DE, 16, 1, "R8");
    run_frame(16'h0000, 0, 1, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule